// File: doc/BRIEF.md
# I2C Controller Status Flag Register

This block holds the eight-bit status word of an I2C controller. Three of its bits are kept here as sticky flags: whether this controller currently owns the bus as master, whether it has lost arbitration, and whether the last received address byte was an extension code. The other five bits are produced elsewhere in the controller and are passed straight through into the low end of the word.

The bus engine drives single-cycle event pulses into the block. These pulses report a start it generated, a start or stop it saw on the bus, an arbitration loss, and the eighth rising clock edge of an address byte together with the byte received. The block also takes a release command, the module enable bit, a CPU read strobe, and a strobe for single-bit writes aimed at some other register. Each flag has its own list of events that set it and events that clear it. A falling enable bit is found inside the block by comparing the enable with its value in the previous cycle.

Top module: `i2c_stat_top`

## Requirements
- R1: While the synchronous reset `rstSync` is high at a clock edge, the three kept flags are 0 after that edge, so `statusOut[7:5]` reads 000.
- R2: `statusOut` is laid out as bit 7 = master flag, bit 6 = arbitration-lost flag, bit 5 = extension-code flag, and bits 4..0 = `otherFlags`, which pass through in the same cycle.
- R3: A `startGen` pulse sets the master flag at the next clock edge, unless `arbLost` is also high in that cycle.
- R4: The master flag clears at the next edge on `stopDet`, on `releaseCmd`, or on an enable fall. If `startGen` arrives in the same cycle, the set wins. `startDet`, `cpuRead` and `bitManipOther` leave the flag unchanged.
- R5: An `arbLost` pulse sets the arbitration-lost flag and forces the master flag to 0 at the next edge. This holds even when `startGen` is high in the same cycle.
- R6: While `cpuRead` is high, `statusOut` shows the flags as they stood before the read. The arbitration-lost flag then reads 0 from the next cycle on, unless `arbLost` is pulsed in the read cycle, in which case it stays 1.
- R7: The arbitration-lost flag also clears on `bitManipOther` (a single-bit write to some other register) and on an enable fall. A simultaneous `arbLost` wins over both.
- R8: On an `addrEdge8` pulse, the extension-code flag sets when `rxAddr[7:4]` is 0000 or 1111. Any other upper nibble leaves the flag unchanged.
- R9: The extension-code flag clears on `startDet`, `stopDet`, `releaseCmd` or an enable fall. A qualifying `addrEdge8` in the same cycle wins.
- R10: An enable fall means `enableBit` is 0 in a cycle after being 1 in the previous cycle. Holding the enable low, or raising it, clears no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstSync | input | 1 | Synchronous reset, active high |
| enableBit | input | 1 | Module enable level |
| startGen | input | 1 | Pulse: this controller generated a start |
| startDet | input | 1 | Pulse: start condition seen on the bus |
| stopDet | input | 1 | Pulse: stop condition seen on the bus |
| arbLost | input | 1 | Pulse: arbitration was lost |
| addrEdge8 | input | 1 | Pulse: eighth rising clock edge of the address byte |
| rxAddr | input | 8 | Address byte received, valid with addrEdge8 |
| releaseCmd | input | 1 | Pulse: exit from communication |
| cpuRead | input | 1 | Pulse: CPU reads the status word |
| bitManipOther | input | 1 | Pulse: single-bit write to a different register |
| otherFlags | input | 5 | Externally kept status bits for bits 4..0 |
| statusOut | output | 8 | Status word |
| masterFlag | output | 1 | Master ownership flag |
| arbLostFlag | output | 1 | Arbitration-lost flag |
| extCodeFlag | output | 1 | Extension-code flag |

## Verification
The assertions watch the cycle-to-cycle behaviour of each flag on every clock. They check that a set event shows up one edge later, that arbitration loss forces master off, that the listed clear events take effect when no set event competes, and that the master flag holds when none of its events arrive. Some behaviour can only be shown by the bench's scenarios: the value a read returns in its own cycle, the full sweep of every event combination against every starting state, the 256-entry address sweep for the extension nibbles, and the difference between an enable held low and an enable that falls.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;

  // Strobes from control to datapath, one set/clear pair per kept flag.
  typedef struct packed {
    logic setMst;
    logic clrMst;
    logic forceMstLow;
    logic setAld;
    logic clrAld;
    logic setExc;
    logic clrExc;
  } flagStrobes_t;

  localparam int KEPT_FLAGS = 3;

endpackage

// File: rtl/i2c_stat_ctrl.sv
module i2c_stat_ctrl
  import i2c_stat_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rstSync,
  input  logic              enableBit,
  input  logic              startGen,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic              arbLost,
  input  logic              addrEdge8,
  input  logic [ADDR_W-1:0] rxAddr,
  input  logic              releaseCmd,
  input  logic              cpuRead,
  input  logic              bitManipOther,
  output flagStrobes_t      strobes
);

  localparam int NIB_LSB = ADDR_W - NIB_W;

  logic             enPrev;
  logic             enFall;
  logic [NIB_W-1:0] upperNib;
  logic             extMatch;

  always_ff @(posedge clk) begin
    if (rstSync) enPrev <= 1'b0;
    else         enPrev <= enableBit;
  end

  assign enFall   = enPrev & ~enableBit;
  assign upperNib = rxAddr[ADDR_W-1:NIB_LSB];

  // The top nibble marks an extension code when it is all zeros or all ones.
  assign extMatch = (upperNib == {NIB_W{1'b0}}) || (upperNib == {NIB_W{1'b1}});

  always_comb begin
    strobes             = '0;
    strobes.setMst      = startGen;
    strobes.clrMst      = stopDet | releaseCmd | enFall;
    strobes.forceMstLow = arbLost;
    strobes.setAld      = arbLost;
    strobes.clrAld      = cpuRead | bitManipOther | enFall;
    strobes.setExc      = addrEdge8 & extMatch;
    strobes.clrExc      = startDet | stopDet | releaseCmd | enFall;
  end

endmodule

// File: rtl/i2c_stat_flagbit.sv
module i2c_stat_flagbit #(
  parameter bit HAS_FORCE = 1'b0
) (
  input  logic clk,
  input  logic rstSync,
  input  logic setEv,
  input  logic clrEv,
  input  logic forceLow,
  output logic flagQ
);

  logic nextQ;
  logic forceEff;

  generate
    if (HAS_FORCE) begin : g_force
      assign forceEff = forceLow;
    end else begin : g_noforce
      assign forceEff = 1'b0;
    end
  endgenerate

  // Priority: forced low, then set, then clear, else hold.
  always_comb begin
    if (forceEff)   nextQ = 1'b0;
    else if (setEv) nextQ = 1'b1;
    else if (clrEv) nextQ = 1'b0;
    else            nextQ = flagQ;
  end

  always_ff @(posedge clk) begin
    if (rstSync) flagQ <= 1'b0;
    else         flagQ <= nextQ;
  end

endmodule

// File: rtl/i2c_stat_dp.sv
module i2c_stat_dp
  import i2c_stat_pkg::*;
#(
  parameter int OTHER_W = 5,
  localparam int STAT_W = OTHER_W + KEPT_FLAGS
) (
  input  logic               clk,
  input  logic               rstSync,
  input  flagStrobes_t       strobes,
  input  logic [OTHER_W-1:0] otherFlags,
  output logic [STAT_W-1:0]  statusOut,
  output logic               masterFlag,
  output logic               arbLostFlag,
  output logic               extCodeFlag
);

  // Index 2 = master, 1 = arbitration lost, 0 = extension code.
  logic [KEPT_FLAGS-1:0] setVec;
  logic [KEPT_FLAGS-1:0] clrVec;
  logic [KEPT_FLAGS-1:0] frcVec;
  logic [KEPT_FLAGS-1:0] flagVec;

  assign setVec = {strobes.setMst, strobes.setAld, strobes.setExc};
  assign clrVec = {strobes.clrMst, strobes.clrAld, strobes.clrExc};
  assign frcVec = {strobes.forceMstLow, 1'b0, 1'b0};

  genvar gi;
  generate
    for (gi = 0; gi < KEPT_FLAGS; gi++) begin : g_flag
      i2c_stat_flagbit #(
        .HAS_FORCE(gi == KEPT_FLAGS - 1)
      ) flag_i (
        .clk     (clk),
        .rstSync (rstSync),
        .setEv   (setVec[gi]),
        .clrEv   (clrVec[gi]),
        .forceLow(frcVec[gi]),
        .flagQ   (flagVec[gi])
      );
    end
  endgenerate

  assign masterFlag  = flagVec[2];
  assign arbLostFlag = flagVec[1];
  assign extCodeFlag = flagVec[0];
  assign statusOut   = {flagVec, otherFlags};

endmodule

// File: rtl/i2c_stat_top.sv
module i2c_stat_top
  import i2c_stat_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int NIB_W   = 4,
  parameter int OTHER_W = 5,
  localparam int STAT_W = OTHER_W + KEPT_FLAGS
) (
  input  logic               clk,
  input  logic               rstSync,
  input  logic               enableBit,
  input  logic               startGen,
  input  logic               startDet,
  input  logic               stopDet,
  input  logic               arbLost,
  input  logic               addrEdge8,
  input  logic [ADDR_W-1:0]  rxAddr,
  input  logic               releaseCmd,
  input  logic               cpuRead,
  input  logic               bitManipOther,
  input  logic [OTHER_W-1:0] otherFlags,
  output logic [STAT_W-1:0]  statusOut,
  output logic               masterFlag,
  output logic               arbLostFlag,
  output logic               extCodeFlag
);

  flagStrobes_t strobes;

  i2c_stat_ctrl #(
    .ADDR_W(ADDR_W),
    .NIB_W (NIB_W)
  ) ctrl_i (
    .clk          (clk),
    .rstSync      (rstSync),
    .enableBit    (enableBit),
    .startGen     (startGen),
    .startDet     (startDet),
    .stopDet      (stopDet),
    .arbLost      (arbLost),
    .addrEdge8    (addrEdge8),
    .rxAddr       (rxAddr),
    .releaseCmd   (releaseCmd),
    .cpuRead      (cpuRead),
    .bitManipOther(bitManipOther),
    .strobes      (strobes)
  );

  i2c_stat_dp #(
    .OTHER_W(OTHER_W)
  ) dp_i (
    .clk        (clk),
    .rstSync    (rstSync),
    .strobes    (strobes),
    .otherFlags (otherFlags),
    .statusOut  (statusOut),
    .masterFlag (masterFlag),
    .arbLostFlag(arbLostFlag),
    .extCodeFlag(extCodeFlag)
  );

endmodule

// File: rtl/i2c_stat_chk.sv
module i2c_stat_chk #(
  parameter int ADDR_W  = 8,
  parameter int NIB_W   = 4,
  parameter int STAT_W  = 8
) (
  input logic              clk,
  input logic              rstSync,
  input logic              enableBit,
  input logic              startGen,
  input logic              startDet,
  input logic              stopDet,
  input logic              arbLost,
  input logic              addrEdge8,
  input logic [ADDR_W-1:0] rxAddr,
  input logic              releaseCmd,
  input logic              cpuRead,
  input logic              bitManipOther,
  input logic [STAT_W-1:0] statusOut,
  input logic              masterFlag,
  input logic              arbLostFlag,
  input logic              extCodeFlag
);

  logic             chkEnPrev;
  logic             chkFall;
  logic [NIB_W-1:0] nib;
  logic             qualEdge;

  always_ff @(posedge clk) begin
    if (rstSync) chkEnPrev <= 1'b0;
    else         chkEnPrev <= enableBit;
  end

  assign chkFall  = chkEnPrev && !enableBit;
  assign nib      = rxAddr[ADDR_W-1 -: NIB_W];
  assign qualEdge = addrEdge8 && ((nib == '0) || (&nib));

  assert_reset_clears_R1: assert property (@(posedge clk)
    rstSync |=> (statusOut[STAT_W-1 -: 3] == 3'b000));

  assert_master_set_R3: assert property (@(posedge clk) disable iff (rstSync)
    (startGen && !arbLost) |=> masterFlag);

  assert_master_clear_R4: assert property (@(posedge clk) disable iff (rstSync)
    ((stopDet || releaseCmd || chkFall) && !startGen && !arbLost) |=> !masterFlag);

  assert_arb_loss_R5: assert property (@(posedge clk) disable iff (rstSync)
    arbLost |=> (arbLostFlag && !masterFlag));

  assert_read_clears_ald_R6: assert property (@(posedge clk) disable iff (rstSync)
    (cpuRead && !arbLost) |=> !arbLostFlag);

  assert_other_clears_ald_R7: assert property (@(posedge clk) disable iff (rstSync)
    ((bitManipOther || chkFall) && !arbLost) |=> !arbLostFlag);

  assert_ext_set_R8: assert property (@(posedge clk) disable iff (rstSync)
    qualEdge |=> extCodeFlag);

  assert_ext_clear_R9: assert property (@(posedge clk) disable iff (rstSync)
    ((startDet || stopDet || releaseCmd || chkFall) && !qualEdge) |=> !extCodeFlag);

  assert_master_hold_R10: assert property (@(posedge clk) disable iff (rstSync)
    (!startGen && !stopDet && !releaseCmd && !arbLost && !chkFall) |=> $stable(masterFlag));

endmodule

bind i2c_stat_top i2c_stat_chk #(
  .ADDR_W(ADDR_W),
  .NIB_W (NIB_W),
  .STAT_W(STAT_W)
) chk_i (
  .clk          (clk),
  .rstSync      (rstSync),
  .enableBit    (enableBit),
  .startGen     (startGen),
  .startDet     (startDet),
  .stopDet      (stopDet),
  .arbLost      (arbLost),
  .addrEdge8    (addrEdge8),
  .rxAddr       (rxAddr),
  .releaseCmd   (releaseCmd),
  .cpuRead      (cpuRead),
  .bitManipOther(bitManipOther),
  .statusOut    (statusOut),
  .masterFlag   (masterFlag),
  .arbLostFlag  (arbLostFlag),
  .extCodeFlag  (extCodeFlag)
);

// File: tb/i2c_stat_top_tb_top.sv
module i2c_stat_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic       clk = 1'b0;
  logic       rstSync, enableBit, startGen, startDet, stopDet, arbLost;
  logic       addrEdge8, releaseCmd, cpuRead, bitManipOther;
  logic [7:0] rxAddr;
  logic [4:0] otherFlags;
  logic [7:0] statusOut;
  logic       masterFlag, arbLostFlag, extCodeFlag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_stat_top dut_i (
    .clk(clk), .rstSync(rstSync), .enableBit(enableBit),
    .startGen(startGen), .startDet(startDet), .stopDet(stopDet),
    .arbLost(arbLost), .addrEdge8(addrEdge8), .rxAddr(rxAddr),
    .releaseCmd(releaseCmd), .cpuRead(cpuRead), .bitManipOther(bitManipOther),
    .otherFlags(otherFlags), .statusOut(statusOut), .masterFlag(masterFlag),
    .arbLostFlag(arbLostFlag), .extCodeFlag(extCodeFlag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    startGen = 0; startDet = 0; stopDet = 0; arbLost = 0; addrEdge8 = 0;
    releaseCmd = 0; cpuRead = 0; bitManipOther = 0; rxAddr = 8'h00;
  endtask

  // Inputs change on the falling edge; the next falling edge samples the result.
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic doReset();
    idle(); rstSync = 1; tick(); rstSync = 0;
  endtask

  // Vector bits: 0 startGen, 1 startDet, 2 stopDet, 3 arbLost, 4 addrEdge8,
  // 5 qualifying nibble, 6 releaseCmd, 7 cpuRead, 8 bitManipOther, 9 enable fall,
  // 10..12 starting state {ext, ald, master}.
  task automatic runVec(input int code);
    bit m0, a0, e0, enF, extSet, mN, aN, eN;
    logic [4:0] oth;
    m0  = code[10]; a0 = code[11]; e0 = code[12];
    enF = code[9];
    oth = code[4:0] ^ code[9:5];
    enableBit = 1; otherFlags = oth;
    doReset();
    if (a0) begin arbLost = 1; tick(); idle(); end
    startGen = m0; addrEdge8 = e0; rxAddr = 8'h0C; tick(); idle();
    startGen      = code[0]; startDet = code[1]; stopDet = code[2];
    arbLost       = code[3]; addrEdge8 = code[4];
    rxAddr        = code[5] ? 8'hF3 : 8'h53;
    releaseCmd    = code[6]; cpuRead = code[7]; bitManipOther = code[8];
    enableBit     = !enF;
    #1;
    // R2 layout and R6 read-before-clear in the event cycle itself.
    check("R2/R6 status in event cycle", statusOut, {m0, a0, e0, oth});
    extSet = code[4] && code[5];
    mN = code[3] ? 1'b0 : code[0] ? 1'b1 : (code[2] || code[6] || enF) ? 1'b0 : m0;
    aN = code[3] ? 1'b1 : (code[7] || code[8] || enF) ? 1'b0 : a0;
    eN = extSet ? 1'b1 : (code[1] || code[2] || code[6] || enF) ? 1'b0 : e0;
    tick(); idle();
    check("R3/R4/R5 master", masterFlag, mN);
    check("R5/R6/R7 arb lost", arbLostFlag, aN);
    check("R8/R9 ext code", extCodeFlag, eN);
  endtask

  initial begin
    rstSync = 1; enableBit = 0; otherFlags = 5'h00; idle();
    tick(); tick();
    check("R1 reset status", statusOut[7:5], 3'b000);
    otherFlags = 5'h15; #1;
    check("R2 passthrough", statusOut[4:0], 5'h15);
    rstSync = 0;

    // Every event combination against every starting state.
    for (int c = 0; c < 8192; c++) runVec(c);

    // Extension sweep over all address bytes (R8).
    for (int a = 0; a < 256; a++) begin
      enableBit = 1; doReset();
      addrEdge8 = 1; rxAddr = a[7:0]; tick(); idle();
      check("R8 addr sweep", extCodeFlag, (a[7:4] == 4'h0) || (a[7:4] == 4'hF));
    end

    // R10: enable held low, then rising, clears nothing.
    enableBit = 1; doReset();
    enableBit = 0; tick();
    startGen = 1; addrEdge8 = 1; rxAddr = 8'h01; tick(); idle();
    arbLost = 1; tick(); idle();
    startGen = 1; tick(); idle();
    for (int k = 0; k < 4; k++) tick();
    check("R10 low enable holds", {masterFlag, arbLostFlag, extCodeFlag}, 3'b111);
    enableBit = 1; tick(); tick();
    check("R10 rising enable holds", {masterFlag, arbLostFlag, extCodeFlag}, 3'b111);
    enableBit = 0; tick();
    check("R10 falling enable clears", {masterFlag, arbLostFlag, extCodeFlag}, 3'b000);

    // R1 reset from an all-set state.
    enableBit = 1; doReset();
    arbLost = 1; tick(); idle();
    startGen = 1; addrEdge8 = 1; rxAddr = 8'hF0; tick(); idle();
    rstSync = 1; tick(); rstSync = 0;
    check("R1 reset from all set", statusOut[7:5], 3'b000);

    done = 1;
  end

  initial begin
    for (int w = 0; w < WATCHDOG_CYCLES && !done; w++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule